// File: doc/BRIEF.md
# Fixed-Priority Shared-Memory Request Arbiter

Up to eight bus masters share one memory and decide its ownership through this block. Each master pulls its own active-low request line. The block returns four things to all of them: the binary index of the winning request, a valid flag, a stable flag and a one-hot grant vector.

Masters use a short software protocol. A master first reads the outputs and waits until it sees the idle state (valid low). It then pulls its line and waits until the stable flag is high. At that point it reads the index back. A master that reads an index other than its own has lost, and it releases its line.

The request lines come from independent masters, so they pass through a two-flop synchronizer before they are encoded. The winner register is updated on every cycle. It always reflects the highest asserted request, which lets a loser see that it has lost. The grant vector behaves differently: once it names an owner, it stays with that owner until the owner releases. A late request with higher priority therefore cannot take the memory away from a master that is in the middle of an access.

Top module: `prio_arb_top`

## Requirements
- R1: While the reset input is low, and immediately after it goes low, every output is zero: index, valid, stable and grant.
- R2: Request line i is asserted when `req_ni[i]` is 0. A request change reaches the index, valid and grant outputs on the third rising clock edge after it is applied. This delay is two synchronizer stages plus one output register. The outputs keep their old values after the second edge.
- R3: `win_idx_o` is the binary number of the highest-numbered asserted request. Line 7 has the highest priority and line 0 the lowest.
- R4: `win_vld_o` is 1 when at least one request is asserted and 0 when none is. `win_idx_o` reads 0 when valid is 0.
- R5: `win_stable_o` rises SETTLE_CYC cycles after the winner register was last updated by a change, provided the synchronized request vector has not changed since (default SETTLE_CYC is 3, so six edges after a change is applied). Any change of the synchronized request vector drives it low on the next edge, even when the winner stays the same.
- R6: `win_stable_o` is never high while `win_vld_o` is low.
- R7: `gnt_o` has at most one bit set, and only for a line that was asserted on the previous cycle. When no grant is held, it goes to the bit of the highest asserted request, with the same latency as R2.
- R8: While the granted master keeps its request asserted, `gnt_o` does not change, even when a higher-numbered request arrives; `win_idx_o` meanwhile shows the higher request. When the owner releases, the grant moves to the highest still-asserted request on the third edge after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_ni | input | NUM_REQ | Active-low request lines, one per master |
| win_idx_o | output | IDX_W | Registered index of the highest asserted request |
| win_vld_o | output | 1 | At least one request is asserted |
| win_stable_o | output | 1 | Request vector has been unchanged for SETTLE_CYC cycles |
| gnt_o | output | NUM_REQ | One-hot grant, held by the owner until it releases |

## Verification
The assertions take for granted that the request lines have settled by the time the second synchronizer flop samples them. They also assume that NUM_REQ is at most 32, so the shared encoder function covers every line.

The bench drives every request change half a clock away from the sampling edge. Each change is held for several cycles, longer than the synchronizer and settle window, so each expected value is defined by one request pattern. The only exception is the directed test of R5, which deliberately changes the pattern while the stable flag is high.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

  localparam int unsigned REQ_DEF    = 8;
  localparam int unsigned SETTLE_DEF = 3;
  localparam int unsigned VEC_MAX    = 32;

  // index of the most significant set bit, 0 when none is set
  function automatic int unsigned top_set(input logic [VEC_MAX-1:0] vec);
    int unsigned pos;
    pos = 0;
    for (int unsigned b = 0; b < VEC_MAX; b++) begin
      if (vec[b]) pos = b;
    end
    return pos;
  endfunction

endpackage

// File: rtl/prio_arb_sync.sv
module prio_arb_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_ni,
  output logic [WIDTH-1:0] act_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] safe_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b1;
        safe_q[g] <= 1'b1;
      end else begin
        meta_q[g] <= lvl_ni[g];
        safe_q[g] <= meta_q[g];
      end
    end
  end

  assign act_o = ~safe_q;

endmodule

// File: rtl/prio_arb_enc.sv
module prio_arb_enc #(
  parameter int unsigned NUM_REQ = 8,
  localparam int unsigned IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               vld_o
);

  import prio_arb_pkg::*;

  logic [IDX_W-1:0] idx_d, idx_q;
  logic             vld_d, vld_q;

  always_comb begin
    vld_d = |req_i;
    idx_d = '0;
    if (vld_d) idx_d = IDX_W'(top_set(VEC_MAX'(req_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      vld_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      vld_q <= vld_d;
    end
  end

  assign idx_o = idx_q;
  assign vld_o = vld_q;

  AST_IDLE_NO_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i) == '0) |-> (!vld_q && idx_q == '0)); // R4
  AST_WIN_IS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (($past(req_i) >> idx_q) == NUM_REQ'(1))); // R3

endmodule

// File: rtl/prio_arb_settle.sv
module prio_arb_settle #(
  parameter int unsigned NUM_REQ    = 8,
  parameter int unsigned SETTLE_CYC = 3,
  localparam int unsigned CNT_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               vld_i,
  output logic               stable_o
);

  logic [NUM_REQ-1:0] prev_q;
  logic               chg;
  logic [CNT_W-1:0]   cnt_d, cnt_q;
  logic               cnt_en;
  logic               full;

  assign full = (cnt_q == CNT_W'(SETTLE_CYC));
  assign chg  = (req_i != prev_q);

  always_comb begin
    cnt_en = chg || !full;
    cnt_d  = cnt_q;
    if (chg) cnt_d = '0;
    else if (!full) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
    end else begin
      prev_q <= req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign stable_o = full && vld_i;

  AST_CHG_CLEARS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != $past(req_i)) |=> !stable_o); // R5
  AST_STABLE_NEEDS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stable_o |-> vld_i); // R6

endmodule

// File: rtl/prio_arb_grant.sv
module prio_arb_grant #(
  parameter int unsigned NUM_REQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] gnt_o
);

  import prio_arb_pkg::*;

  logic [NUM_REQ-1:0] gnt_d, gnt_q;
  logic               owner_live;
  logic               gnt_en;

  assign owner_live = |(gnt_q & req_i);

  always_comb begin
    gnt_en = !owner_live;
    gnt_d  = '0;
    if (|req_i) gnt_d = NUM_REQ'(1) << top_set(VEC_MAX'(req_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
    end else if (gnt_en) begin
      gnt_q <= gnt_d;
    end
  end

  assign gnt_o = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q)); // R7
  AST_GNT_TO_REQUESTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q != '0) |-> ((gnt_q & $past(req_i)) != '0)); // R7
  AST_GNT_NO_PREEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_q & req_i) != '0) |=> (gnt_q == $past(gnt_q))); // R8

endmodule

// File: rtl/prio_arb_top.sv
module prio_arb_top #(
  parameter int unsigned NUM_REQ    = prio_arb_pkg::REQ_DEF,
  parameter int unsigned SETTLE_CYC = prio_arb_pkg::SETTLE_DEF,
  localparam int unsigned IDX_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_ni,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic               win_vld_o,
  output logic               win_stable_o,
  output logic [NUM_REQ-1:0] gnt_o
);

  logic [1:0]         rst_pipe_q;
  logic               rst_n;
  logic [NUM_REQ-1:0] req_s;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n = rst_pipe_q[1];

  prio_arb_sync #(.WIDTH(NUM_REQ)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .lvl_ni (req_ni),
    .act_o  (req_s)
  );

  prio_arb_enc #(.NUM_REQ(NUM_REQ)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .req_i  (req_s),
    .idx_o  (win_idx_o),
    .vld_o  (win_vld_o)
  );

  prio_arb_settle #(.NUM_REQ(NUM_REQ), .SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .req_i    (req_s),
    .vld_i    (win_vld_o),
    .stable_o (win_stable_o)
  );

  prio_arb_grant #(.NUM_REQ(NUM_REQ)) u_grant (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .req_i  (req_s),
    .gnt_o  (gnt_o)
  );

  AST_RST_OUTPUTS_ZERO: assert property (@(posedge clk_i)
    !rst_n |-> (gnt_o == '0 && !win_vld_o && !win_stable_o && win_idx_o == '0)); // R1
  AST_PARAM_RANGE: assert property (@(posedge clk_i)
    (NUM_REQ <= prio_arb_pkg::VEC_MAX) && (SETTLE_CYC >= 1)); // R3

endmodule

// File: tb/prio_arb_top_tb_top.sv
module prio_arb_top_tb_top;

  localparam int unsigned N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req_n;
  logic [2:0]   idx;
  logic         vld;
  logic         stb;
  logic [N-1:0] gnt;

  int n_chk;
  int n_bad;
  bit done;

  prio_arb_top dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_ni       (req_n),
    .win_idx_o    (idx),
    .win_vld_o    (vld),
    .win_stable_o (stb),
    .gnt_o        (gnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {req_n, exp idx, exp valid, exp grant} applied from the idle state
  localparam logic [19:0] VEC [9] = '{
    {8'hFF, 3'd0, 1'b0, 8'h00},
    {8'hFE, 3'd0, 1'b1, 8'h01},
    {8'h7F, 3'd7, 1'b1, 8'h80},
    {8'hF0, 3'd3, 1'b1, 8'h08},
    {8'h00, 3'd7, 1'b1, 8'h80},
    {8'hAA, 3'd6, 1'b1, 8'h40},
    {8'hFB, 3'd2, 1'b1, 8'h04},
    {8'h5F, 3'd7, 1'b1, 8'h80},
    {8'hEF, 3'd4, 1'b1, 8'h10}
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    req_n = '1;
    step(3);
    chk("R1", "idx in reset", 32'(idx), 0);
    chk("R1", "vld in reset", 32'(vld), 0);
    chk("R1", "stable in reset", 32'(stb), 0);
    chk("R1", "gnt in reset", 32'(gnt), 0);
    rst_n = 1'b1;
    step(6);

    for (int k = 0; k < 9; k++) begin
      req_n = VEC[k][19:12];
      step(10);
      chk("R3", "table idx", 32'(idx), 32'(VEC[k][11:9]));
      chk("R4", "table vld", 32'(vld), 32'(VEC[k][8]));
      chk("R6", "table stable", 32'(stb), 32'(VEC[k][8]));
      chk("R7", "table gnt", 32'(gnt), 32'(VEC[k][7:0]));
      req_n = '1;
      step(10);
      chk("R4", "idle vld", 32'(vld), 0);
      chk("R4", "idle idx", 32'(idx), 0);
      chk("R6", "idle stable", 32'(stb), 0);
    end

    // latency and stable timing, line 1
    req_n = 8'hFD;
    step(2);
    chk("R2", "vld after two edges", 32'(vld), 0);
    chk("R2", "gnt after two edges", 32'(gnt), 0);
    step(1);
    chk("R2", "vld after three edges", 32'(vld), 1);
    chk("R2", "idx after three edges", 32'(idx), 1);
    chk("R7", "gnt after three edges", 32'(gnt), 32'h02);
    step(2);
    chk("R5", "stable before window", 32'(stb), 0);
    step(1);
    chk("R5", "stable at window", 32'(stb), 1);

    // higher request arrives while line 1 owns the grant
    req_n = 8'hBD;
    step(10);
    chk("R8", "idx shows higher", 32'(idx), 6);
    chk("R8", "gnt held by owner", 32'(gnt), 32'h02);
    req_n = 8'hBF;
    step(2);
    chk("R8", "gnt before handover", 32'(gnt), 32'h02);
    step(1);
    chk("R8", "gnt after handover", 32'(gnt), 32'h40);
    step(10);

    // change without a new winner still clears stable
    chk("R5", "stable before change", 32'(stb), 1);
    req_n = 8'hBE;
    step(2);
    chk("R5", "stable two edges after change", 32'(stb), 1);
    step(1);
    chk("R5", "stable cleared by change", 32'(stb), 0);
    chk("R3", "winner unchanged", 32'(idx), 6);
    step(10);
    chk("R5", "stable again", 32'(stb), 1);
    chk("R8", "gnt still line 6", 32'(gnt), 32'h40);

    // asynchronous reset during operation
    rst_n = 1'b0;
    #1;
    chk("R1", "gnt at reset assert", 32'(gnt), 0);
    chk("R1", "vld at reset assert", 32'(vld), 0);
    chk("R1", "stable at reset assert", 32'(stb), 0);
    step(2);
    rst_n = 1'b1;
    step(12);
    chk("R7", "gnt after reset release", 32'(gnt), 32'h40);
    chk("R3", "idx after reset release", 32'(idx), 6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule